// File: doc/BRIEF.md
# Thermal Sprint Governor

This block picks the operating point of a four-core processor that runs above its sustainable power for short periods. An idle chip rests in its sustainable configuration, which is one core at the slowest frequency level. When a job arrives, the governor starts a sprint. It records the die temperature at that moment as the idle baseline. Temperature samples arrive on a periodic sampling strobe, nominally every 100 ms. The governor compares each sample against a fixed limit, and in adaptive mode also against an estimate of how much thermal headroom has been used.

A sampled temperature at or above the limit ends the sprint early. The truncation runs as three ordered steps, and the next step is issued only after an acknowledge arrives. First the governor asks software to gather all threads onto one core. Next it powers every other core down. Last it drops the surviving core to the slowest level. At the start of truncation the desired worker count falls to one, so that worker threads with an index of one or higher stop taking work.

After the job ends, the governor will not begin another sprint until a sample shows the die has cooled to within a programmable margin of the baseline. The pacing mode is captured when the sprint begins.

Top module: `sprint_governor`

## Requirements
- R1: After reset, and whenever no sprint is active, the outputs hold the sustainable point: core mask 4'b0001, frequency level 0, migrate request low, worker count 1. The core mask is always either 4'b0001 or 4'b1111.
- R2: A job_start pulse while resting sets the outputs on the next clock to mask 4'b1111, level 4 (the fastest of the five levels 4..0 = 3.2, 2.8, 2.4, 2.0, 1.6 GHz) and worker count 4. The same pulse latches die_temp as the baseline and mode_adaptive as the pacing mode.
- R3: During a sprint, a sample of 75 or more starts truncation. Two clocks after the sampling strobe, migrate_req is high and the worker count is 1, while the mask and level are unchanged. A sample of 74 changes nothing.
- R4: An acknowledge while migrate_req is high lowers migrate_req and sets the mask to 4'b0001 on the next clock, with the level unchanged.
- R5: The next acknowledge sets the level to 0. No truncation step advances without an acknowledge, and migrate_req stays high until it is acknowledged.
- R6: In adaptive mode (mode_adaptive=1 at start), a sample whose rise above the baseline is at least floor((75 - baseline)/2) sets the level to 0 with the mask still 4'b1111 and worker count 4. A rise one less has no effect.
- R7: In maximum-intensity mode (mode_adaptive=0 at start), the sprint stays at level 4 with all cores until truncation or job end.
- R8: job_done during a sprint returns the outputs to the sustainable point on the next clock. A new job_start is then ignored until a sample no greater than baseline + cool_margin has been taken.
- R9: job_start is ignored outside the resting state, and changes of mode_adaptive during a sprint are ignored.
- R10: die_temp only matters on a sampling strobe; changes without a strobe have no effect.
- R11: job_done that arrives during truncation lets the sequence finish and then enters the cool-down wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| job_start | input | 1 | Pulse: a job has arrived |
| job_done | input | 1 | Pulse: the job has completed |
| mode_adaptive | input | 1 | 1 = adaptive pacing, 0 = maximum intensity; taken at sprint start |
| sample_tick | input | 1 | Periodic sampling strobe |
| die_temp | input | 8 | Die temperature in whole degrees C |
| cool_margin | input | 8 | Allowed distance above baseline before re-arming |
| step_ack | input | 1 | Acknowledge of the pending truncation step |
| core_en | output | 4 | Core enable mask |
| freq_lvl | output | 3 | Frequency level, 4 fastest, 0 slowest |
| migrate_req | output | 1 | Request to move all threads onto one core |
| worker_limit | output | 3 | Desired number of active workers |

## Verification
The bench sweeps baselines from 40 to 70 degrees in adaptive mode and probes each pacing threshold one degree below and exactly at it. An off-by-one in the half-budget compare would pace a sample early or late. It also sweeps samples from 70 to 80 in maximum mode. A wrong limit compare would truncate at 74 or miss 75, and a mode leak would pace a maximum-intensity sprint. Truncation is stepped with stalled acknowledges, so a design that runs ahead of software would be caught disabling cores while threads still run on them. The cool-down gate is tested one degree above and exactly at baseline plus margin. A job completion inside the truncation sequence checks that the order is not cut short.

// File: rtl/gov_pkg.sv
package gov_pkg;

    localparam int NCORE   = 4;
    localparam int LVL_W   = 3;
    localparam int LVL_MAX = 4;
    localparam int TEMP_W  = 8;
    localparam int WRK_W   = $clog2(NCORE + 1);

    typedef logic [NCORE-1:0]  core_mask_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [TEMP_W-1:0] temp_t;
    typedef logic [WRK_W-1:0]  wrk_t;

    typedef enum logic [2:0] {
        ST_REST,   // sustainable, waiting for a job
        ST_BURST,  // all cores, top level
        ST_PACED,  // all cores, bottom level (adaptive)
        ST_MOVE,   // step 1: gather threads
        ST_GATE,   // step 2: power down spare cores
        ST_SLOW,   // step 3: lowest level on the last core
        ST_TAIL,   // job continues at sustainable point
        ST_COOL    // job over, waiting for die to cool
    } gov_state_t;

    typedef struct packed {
        core_mask_t cores;
        lvl_t       lvl;
        logic       move;
        wrk_t       workers;
    } op_point_t;

    localparam core_mask_t ALL_CORES = '1;
    localparam core_mask_t ONE_CORE  = core_mask_t'(1);

    localparam op_point_t OP_REST = '{cores: ONE_CORE, lvl: '0, move: 1'b0,
                                      workers: wrk_t'(1)};

    // Operating point for a state; paced tells what level the sprint had
    // reached before truncation began, so the level is held during steps 1-2.
    function automatic op_point_t op_for(gov_state_t s, logic paced);
        op_point_t o;
        lvl_t held;
        held = paced ? lvl_t'(0) : lvl_t'(LVL_MAX);
        o = OP_REST;
        case (s)
            ST_BURST: o = '{cores: ALL_CORES, lvl: lvl_t'(LVL_MAX), move: 1'b0,
                            workers: wrk_t'(NCORE)};
            ST_PACED: o = '{cores: ALL_CORES, lvl: '0, move: 1'b0,
                            workers: wrk_t'(NCORE)};
            ST_MOVE:  o = '{cores: ALL_CORES, lvl: held, move: 1'b1,
                            workers: wrk_t'(1)};
            ST_GATE:  o = '{cores: ONE_CORE, lvl: held, move: 1'b0,
                            workers: wrk_t'(1)};
            default:  o = OP_REST;
        endcase
        return o;
    endfunction

    // Has the rise above baseline reached half of the headroom to the limit?
    function automatic logic half_spent(temp_t t, temp_t b, temp_t lim);
        logic [TEMP_W:0] rise;
        logic [TEMP_W:0] room;
        rise = (t > b)   ? ({1'b0, t} - {1'b0, b})          : '0;
        room = (lim > b) ? (({1'b0, lim} - {1'b0, b}) >> 1) : '0;
        return rise >= room;
    endfunction

    function automatic logic cooled(temp_t t, temp_t b, temp_t m);
        return {1'b0, t} <= ({1'b0, b} + {1'b0, m});
    endfunction

endpackage

// File: rtl/gov_sampler.sv
module gov_sampler
    import gov_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sample_tick,
    input  temp_t die_temp,
    output logic  smp_vld,
    output temp_t smp_temp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            smp_vld  <= 1'b0;
            smp_temp <= '0;
        end else begin
            smp_vld <= sample_tick;
            if (sample_tick)
                smp_temp <= die_temp;
        end
    end
endmodule

// File: rtl/gov_budget.sv
module gov_budget
    import gov_pkg::*;
#(
    parameter temp_t LIMIT = temp_t'(75)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  capture,
    input  temp_t die_temp,
    input  temp_t smp_temp,
    input  temp_t cool_margin,
    output logic  over_limit,
    output logic  half_hit,
    output logic  cool_ok
);
    temp_t base_q;

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (capture)
            base_q <= die_temp;
    end

    always_comb begin
        over_limit = (smp_temp >= LIMIT);
        half_hit   = half_spent(smp_temp, base_q, LIMIT);
        cool_ok    = cooled(smp_temp, base_q, cool_margin);
    end
endmodule

// File: rtl/gov_fsm.sv
module gov_fsm
    import gov_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      job_start,
    input  logic      job_done,
    input  logic      mode_adaptive,
    input  logic      step_ack,
    input  logic      smp_vld,
    input  logic      over_limit,
    input  logic      half_hit,
    input  logic      cool_ok,
    output logic      capture,
    output op_point_t op
);
    gov_state_t state_q, state_d;
    logic paced_q, paced_d;
    logic mode_q, mode_d;
    logic done_q, done_d;
    op_point_t op_q;

    always_comb begin
        state_d = state_q;
        paced_d = paced_q;
        mode_d  = mode_q;
        done_d  = done_q;
        capture = 1'b0;
        case (state_q)
            ST_REST: begin
                if (job_start) begin
                    state_d = ST_BURST;
                    capture = 1'b1;
                    paced_d = 1'b0;
                    mode_d  = mode_adaptive;
                end
            end
            ST_BURST: begin
                if (job_done)
                    state_d = ST_COOL;
                else if (smp_vld && over_limit) begin
                    state_d = ST_MOVE;
                    done_d  = 1'b0;
                end else if (smp_vld && mode_q && half_hit) begin
                    state_d = ST_PACED;
                    paced_d = 1'b1;
                end
            end
            ST_PACED: begin
                if (job_done)
                    state_d = ST_COOL;
                else if (smp_vld && over_limit) begin
                    state_d = ST_MOVE;
                    done_d  = 1'b0;
                end
            end
            ST_MOVE: begin
                done_d = done_q | job_done;
                if (step_ack)
                    state_d = ST_GATE;
            end
            ST_GATE: begin
                done_d = done_q | job_done;
                if (step_ack)
                    state_d = ST_SLOW;
            end
            ST_SLOW: begin
                done_d = done_q | job_done;
                if (step_ack)
                    state_d = (done_q | job_done) ? ST_COOL : ST_TAIL;
            end
            ST_TAIL: begin
                if (job_done)
                    state_d = ST_COOL;
            end
            ST_COOL: begin
                if (smp_vld && cool_ok)
                    state_d = ST_REST;
            end
            default: state_d = ST_REST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_REST;
            paced_q <= 1'b0;
            mode_q  <= 1'b0;
            done_q  <= 1'b0;
            op_q    <= OP_REST;
        end else begin
            state_q <= state_d;
            paced_q <= paced_d;
            mode_q  <= mode_d;
            done_q  <= done_d;
            op_q    <= op_for(state_d, paced_d);
        end
    end

    assign op = op_q;
endmodule

// File: rtl/sprint_governor.sv
module sprint_governor
    import gov_pkg::*;
#(
    parameter int TEMP_LIMIT = 75
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              job_start,
    input  logic              job_done,
    input  logic              mode_adaptive,
    input  logic              sample_tick,
    input  logic [TEMP_W-1:0] die_temp,
    input  logic [TEMP_W-1:0] cool_margin,
    input  logic              step_ack,
    output logic [NCORE-1:0]  core_en,
    output logic [LVL_W-1:0]  freq_lvl,
    output logic              migrate_req,
    output logic [WRK_W-1:0]  worker_limit
);
    logic      smp_vld;
    temp_t     smp_temp;
    logic      over_limit, half_hit, cool_ok, capture;
    op_point_t op;

    gov_sampler u_smp (
        .clk         (clk),
        .rst         (rst),
        .sample_tick (sample_tick),
        .die_temp    (die_temp),
        .smp_vld     (smp_vld),
        .smp_temp    (smp_temp)
    );

    gov_budget #(.LIMIT(temp_t'(TEMP_LIMIT))) u_bud (
        .clk         (clk),
        .rst         (rst),
        .capture     (capture),
        .die_temp    (die_temp),
        .smp_temp    (smp_temp),
        .cool_margin (cool_margin),
        .over_limit  (over_limit),
        .half_hit    (half_hit),
        .cool_ok     (cool_ok)
    );

    gov_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .job_start     (job_start),
        .job_done      (job_done),
        .mode_adaptive (mode_adaptive),
        .step_ack      (step_ack),
        .smp_vld       (smp_vld),
        .over_limit    (over_limit),
        .half_hit      (half_hit),
        .cool_ok       (cool_ok),
        .capture       (capture),
        .op            (op)
    );

    assign core_en      = op.cores;
    assign freq_lvl     = op.lvl;
    assign migrate_req  = op.move;
    assign worker_limit = op.workers;
endmodule

// File: rtl/sprint_governor_check.sv
module sprint_governor_check
    import gov_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              job_start,
    input logic              job_done,
    input logic              sample_tick,
    input logic              step_ack,
    input logic [NCORE-1:0]  core_en,
    input logic [LVL_W-1:0]  freq_lvl,
    input logic              migrate_req,
    input logic [WRK_W-1:0]  worker_limit
);
    // R1: mask is one core or all cores
    a_r1_mask_shape: assert property (@(posedge clk) disable iff (rst)
        (core_en == ALL_CORES) || (core_en == ONE_CORE));

    // R2: top level appears only right after a job start, with all cores
    a_r2_burst_from_start: assert property (@(posedge clk) disable iff (rst)
        (freq_lvl == lvl_t'(LVL_MAX) && $past(freq_lvl) != lvl_t'(LVL_MAX))
        |-> ($past(job_start) && core_en == ALL_CORES
             && worker_limit == wrk_t'(NCORE)));

    // R3: migrate request comes with one worker and all cores still on
    a_r3_move_single_worker: assert property (@(posedge clk) disable iff (rst)
        $rose(migrate_req) |-> (worker_limit == wrk_t'(1) && core_en == ALL_CORES));

    // R4: cores drop only after the migrate step was acknowledged
    a_r4_gate_after_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(migrate_req) |-> (core_en == ONE_CORE && $past(step_ack)));

    // R5: an unacknowledged migrate request is held
    a_r5_move_holds: assert property (@(posedge clk) disable iff (rst)
        (migrate_req && !step_ack) |=> migrate_req);

    // R6: pacing drop follows a sampling strobe
    a_r6_pace_on_sample: assert property (@(posedge clk) disable iff (rst)
        ($past(freq_lvl) == lvl_t'(LVL_MAX) && freq_lvl == '0 && core_en == ALL_CORES)
        |-> $past(sample_tick, 2));

    // R8: all-to-one core drop needs an ack or a job end
    a_r8_drop_cause: assert property (@(posedge clk) disable iff (rst)
        ($past(core_en) == ALL_CORES && core_en == ONE_CORE)
        |-> ($past(step_ack) || $past(job_done)));
endmodule

bind sprint_governor sprint_governor_check u_chk (
    .clk          (clk),
    .rst          (rst),
    .job_start    (job_start),
    .job_done     (job_done),
    .sample_tick  (sample_tick),
    .step_ack     (step_ack),
    .core_en      (core_en),
    .freq_lvl     (freq_lvl),
    .migrate_req  (migrate_req),
    .worker_limit (worker_limit)
);

// File: tb/sprint_governor_test.sv
module sprint_governor_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 75;
    localparam int MARGIN     = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       job_start = 0, job_done = 0, mode_adaptive = 0;
    logic       sample_tick = 0, step_ack = 0;
    logic [7:0] die_temp = 8'd50;
    logic [7:0] cool_margin = 8'(MARGIN);
    logic [3:0] core_en;
    logic [2:0] freq_lvl;
    logic       migrate_req;
    logic [2:0] worker_limit;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    sprint_governor uut (
        .clk(clk), .rst(rst), .job_start(job_start), .job_done(job_done),
        .mode_adaptive(mode_adaptive), .sample_tick(sample_tick),
        .die_temp(die_temp), .cool_margin(cool_margin), .step_ack(step_ack),
        .core_en(core_en), .freq_lvl(freq_lvl), .migrate_req(migrate_req),
        .worker_limit(worker_limit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic [3:0] c, input logic [2:0] l, input logic m,
                       input logic [2:0] w, input string req);
        checks++;
        if (core_en !== c || freq_lvl !== l || migrate_req !== m || worker_limit !== w) begin
            errors++;
            $display("FAIL %s: actual cores=%b lvl=%0d mig=%b wrk=%0d expected cores=%b lvl=%0d mig=%b wrk=%0d",
                     req, core_en, freq_lvl, migrate_req, worker_limit, c, l, m, w);
        end
    endtask

    task automatic start(input logic mode, input int base);
        die_temp = 8'(base); mode_adaptive = mode; job_start = 1;
        @(negedge clk); job_start = 0;
    endtask

    task automatic tick(input int t);
        die_temp = 8'(t); sample_tick = 1;
        @(negedge clk); sample_tick = 0;
        @(negedge clk);
    endtask

    task automatic ack();
        step_ack = 1; @(negedge clk); step_ack = 0;
    endtask

    task automatic done();
        job_done = 1; @(negedge clk); job_done = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(4'b0001, 0, 0, 1, "R1 reset");

        // Adaptive sweep over baselines
        for (int base = 40; base <= 70; base += 10) begin
            int half;
            half = (LIMIT - base) / 2;
            start(1, base);
            chk(4'b1111, 4, 0, 4, "R2 start");
            tick(base + half - 1);
            chk(4'b1111, 4, 0, 4, "R6 below half");
            tick(base + half);
            chk(4'b1111, 0, 0, 4, "R6 at half");
            tick(LIMIT - 1);
            chk(4'b1111, 0, 0, 4, "R3 74 ignored");
            tick(LIMIT);
            chk(4'b1111, 0, 1, 1, "R3 truncate");
            repeat (3) @(negedge clk);
            chk(4'b1111, 0, 1, 1, "R5 waits for ack");
            ack();
            chk(4'b0001, 0, 0, 1, "R4 gate");
            ack();
            chk(4'b0001, 0, 0, 1, "R5 slow");
            ack();
            done();
            chk(4'b0001, 0, 0, 1, "R8 job end");
            tick(base + MARGIN + 1);
            start(0, base);
            chk(4'b0001, 0, 0, 1, "R8 blocked while warm");
            tick(base + MARGIN);
            chk(4'b0001, 0, 0, 1, "R1 rest");
        end

        // Maximum-intensity sweep across the limit
        for (int t = 70; t <= 80; t++) begin
            start(0, 60);
            chk(4'b1111, 4, 0, 4, "R2 start max");
            tick(t);
            if (t >= LIMIT) begin
                chk(4'b1111, 4, 1, 1, "R3 truncate at limit");
                ack();
                chk(4'b0001, 4, 0, 1, "R4 level held");
                ack();
                chk(4'b0001, 0, 0, 1, "R5 lowest level");
                ack();
                chk(4'b0001, 0, 0, 1, "R5 tail");
                done();
            end else begin
                chk(4'b1111, 4, 0, 4, "R7 no pacing");
                done();
                chk(4'b0001, 0, 0, 1, "R8 sustainable after done");
            end
            tick(60);
        end

        // R9 and R10: mode change, extra start and unsampled temperature
        start(0, 50);
        mode_adaptive = 1;
        die_temp = 8'd95;
        repeat (4) @(negedge clk);
        chk(4'b1111, 4, 0, 4, "R10 no strobe no effect");
        start(1, 50);
        tick(65);
        chk(4'b1111, 4, 0, 4, "R9 latched mode");

        // R11: job ends inside truncation
        tick(76);
        chk(4'b1111, 4, 1, 1, "R11 truncate");
        ack();
        done();
        chk(4'b0001, 4, 0, 1, "R11 sequence continues");
        ack();
        chk(4'b0001, 0, 0, 1, "R11 slow step");
        ack();
        start(0, 50);
        chk(4'b0001, 0, 0, 1, "R11 cool-down wait");
        tick(53);
        start(0, 50);
        chk(4'b1111, 4, 0, 4, "R11 re-armed");
        done();
        tick(50);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule